// File: doc/BRIEF.md
# I2C Register Target with Alert Response

This block is a register-access target on a two-wire serial bus. It oversamples the clock and data lines with the system clock and pulls the data line low through an open-drain enable. Register reads and writes go through an eight-bit pointer. The pointer is loaded by the first byte of a write transaction and advances by one after every byte moved in either direction. The register storage sits outside the block. The block reaches it through one-cycle read and write strobes that carry the pointer as the address.

The block also owns an active-low alert line. A pulse on `alert_evt` makes the block pull the alert line. The line is released only when a bus controller runs a complete alert response cycle:

1. The controller reads from the shared alert response address.
2. The block acknowledges that address.
3. The block returns its own address followed by a zero bit.

The block checks every bit it sends in that response. If another target wins the bit-wise arbitration, the block stops driving at once and keeps its alert for a later attempt. A separate pulse tells the surrounding logic that the status register (pointer 0x00) has been read, so that its flags can be cleared.

Top module: `i2c_alert_target`

## Requirements
- R1: An address byte whose upper seven bits are 1100100 is acknowledged. With bit 0 = 0 it starts a write; with bit 0 = 1 it starts a read. Any other address byte is not acknowledged, except the accepted alert response described in R7. After such a byte the block ignores the bus until the next START.
- R2: In a write, the first data byte is acknowledged and loaded into the pointer. Each later byte is acknowledged and produces one `reg_wr` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments modulo 256, so 0xFF is followed by 0x00.
- R3: In a read, bytes are sent MSB first from `reg_rdata` at the pointer. Each byte fetched produces one `reg_rd` pulse and a pointer increment. The next byte is fetched only when the controller acknowledges. After a not-acknowledge, the block sends nothing more, and the pointer is kept for the next transaction.
- R4: A repeated START behaves like a START. A STOP is SDA rising while SCL is high. A STOP returns the block to idle with SDA released.
- R5: `status_rd` pulses together with `reg_rd` exactly when the byte fetched is at pointer 0x00.
- R6: A pulse on `alert_evt` sets `alert_pull` on the next cycle. `alert_pull` stays set through any bus traffic until a successful alert response.
- R7: An address byte of 0001100 with bit 0 = 1 is acknowledged only while `alert_pull` is set. The block then sends 0xC8 (its address 1100100 followed by 0). After that byte completes, `alert_pull` is cleared.
- R8: During the response byte, if the block leaves SDA high but samples it low at a rising SCL, it releases SDA for the rest of the byte. In that case `alert_pull` stays set, and a later response cycle is answered again.
- R9: After a successful response, alert response addresses are not acknowledged until a new `alert_evt` pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| alert_evt | input | 1 | One-cycle pulse requesting an alert |
| alert_pull | output | 1 | 1 pulls the alert line low |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe (data taken in the same cycle) |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr` |
| status_rd | output | 1 | Pulse when the status register is fetched |

## Verification
The hardest case to reach is lost arbitration in the middle of the alert response. It needs a second target on the wired-AND data line, and that target must win on a bit where this block sends a 1. The bench plays that target inside its read task by pulling SDA according to a competing address, 0x43. The value read back shows whether the block really released the line: 0x43 if it did, 0x40 if it kept driving. The bench then runs a clean response cycle to show that the alert was kept and is answered afterwards.

// File: rtl/i2c_alert_target.sv
module i2c_alert_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b1100100,
  parameter logic [6:0] ARA_ADDR    = 7'b0001100,
  parameter logic [7:0] STATUS_ADDR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       alert_evt,
  output logic       alert_pull,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  output logic       status_rd
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WPTR, S_WDATA, S_RDATA, S_ARA} st_t;

  st_t        st, nst;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, tsh, ptr, txn;
  logic       mack;

  wire scl_s = scl_p[1], scl_q = scl_p[2];
  wire sda_s = sda_p[1], sda_q = sda_p[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire rx = (st == S_ADDR) || (st == S_WPTR) || (st == S_WDATA);
  wire in_ara = (st == S_ARA);
  wire tx = (st == S_RDATA) || in_ara;

  wire rd_ld  = scl_fall && cnt == 4'd9 &&
                ((rx && nst == S_RDATA) || (st == S_RDATA && mack));
  wire ara_ld = scl_fall && cnt == 4'd9 && rx && nst == S_ARA;

  assign txn       = ara_ld ? {DEV_ADDR, 1'b0} : reg_rdata;
  assign reg_rd    = rd_ld;
  assign status_rd = rd_ld && ptr == STATUS_ADDR;
  assign reg_wr    = scl_fall && cnt == 4'd8 && st == S_WDATA;
  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1;
      st <= S_IDLE; nst <= S_IDLE;
      cnt <= '0; sh <= '0; tsh <= '0; ptr <= '0;
      mack <= 1'b0; sda_oe <= 1'b0; alert_pull <= 1'b0;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            if (rx) sh <= {sh[6:0], sda_s};
            if (in_ara && !sda_oe && !sda_s) st <= S_IDLE;
          end else if (cnt == 4'd8 && tx) begin
            mack <= ~sda_s;
            cnt  <= 4'd9;
          end
        end
        if (scl_fall) begin
          if (rx && cnt == 4'd8) begin
            cnt <= 4'd9;
            sda_oe <= 1'b1;
            case (st)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) nst <= sh[0] ? S_RDATA : S_WPTR;
                else if (sh[7:1] == ARA_ADDR && sh[0] && alert_pull) nst <= S_ARA;
                else begin st <= S_IDLE; sda_oe <= 1'b0; end
              S_WPTR:  begin ptr <= sh; nst <= S_WDATA; end
              default: begin ptr <= ptr + 8'd1; nst <= S_WDATA; end
            endcase
          end else if (rx && cnt == 4'd9) begin
            st <= nst; cnt <= '0; tsh <= txn;
            sda_oe <= (rd_ld || ara_ld) ? ~txn[7] : 1'b0;
            if (rd_ld) ptr <= ptr + 8'd1;
          end else if (tx && cnt >= 4'd1 && cnt <= 4'd7) begin
            tsh <= {tsh[6:0], 1'b0};
            sda_oe <= ~tsh[6];
          end else if (tx && cnt == 4'd8) begin
            sda_oe <= 1'b0;
            if (in_ara) begin alert_pull <= 1'b0; st <= S_IDLE; end
          end else if (tx && cnt == 4'd9) begin
            if (mack) begin
              tsh <= txn; sda_oe <= ~txn[7]; cnt <= '0; ptr <= ptr + 8'd1;
            end else st <= S_IDLE;
          end
        end
      end
      if (alert_evt) alert_pull <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_alert_target_chk.sv
module i2c_alert_target_chk #(
  parameter logic [7:0] STATUS_ADDR = 8'h00
) (
  input logic       clk,
  input logic       rst_n,
  input logic       alert_evt,
  input logic       alert_pull,
  input logic       in_ara,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic       status_rd
);
  a_r6_alert_set: assert property (@(posedge clk) disable iff (!rst_n)
    alert_evt |=> alert_pull);
  a_r6_alert_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pull && !in_ara) |=> alert_pull);
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == $past(reg_addr) + 8'd1);
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_addr == $past(reg_addr) + 8'd1);
  a_r5_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |-> (reg_rd && reg_addr == STATUS_ADDR));
  a_r4_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

bind i2c_alert_target i2c_alert_target_chk #(.STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .alert_evt(alert_evt), .alert_pull(alert_pull),
  .in_ara(in_ara), .stop_det(stop_det), .sda_oe(sda_oe), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .status_rd(status_rd)
);

// File: tb/i2c_alert_target_tb.sv
module i2c_alert_target_tb;
  localparam int CLK_NS = 10;
  localparam int T = 10;
  localparam logic [6:0] DEV = 7'b1100100;
  localparam logic [6:0] ARA = 7'b0001100;

  logic clk = 0, rst_n = 0, m_scl = 1, m_low = 0, alert_evt = 0;
  logic sda_oe, alert_pull, reg_wr, reg_rd, status_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] em [256];
  int checks = 0, errs = 0, n_wr = 0, n_rd = 0, n_st = 0;
  bit done = 0;
  wire sda_bus = ~(m_low | sda_oe);

  always #(CLK_NS/2) clk = ~clk;

  i2c_alert_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .alert_evt(alert_evt), .alert_pull(alert_pull), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_rd(status_rd)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (reg_wr) n_wr++;
    if (reg_rd) n_rd++;
    if (status_rd) n_st++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_t(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 0; wait_t(T); m_scl = 1; wait_t(T); m_low = 1; wait_t(T); m_scl = 0; wait_t(T);
  endtask

  task automatic i2c_stop();
    m_low = 1; wait_t(T); m_scl = 1; wait_t(T); m_low = 0; wait_t(T);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wait_t(T); m_scl = 1; wait_t(2*T); m_scl = 0; wait_t(T);
    end
    m_low = 0; wait_t(T); m_scl = 1; wait_t(T); ack = ~sda_bus; wait_t(T); m_scl = 0; wait_t(T);
  endtask

  task automatic rbyte(input logic [7:0] pat, input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~pat[i]; wait_t(T); m_scl = 1; wait_t(T); b[i] = sda_bus; wait_t(T); m_scl = 0; wait_t(T);
    end
    m_low = give_ack; wait_t(T); m_scl = 1; wait_t(2*T); m_scl = 0; wait_t(T);
    m_low = 0;
  endtask

  task automatic wr_regs(input logic [7:0] p, input int n, input logic [7:0] seed);
    logic ack;
    logic [7:0] q;
    q = p;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); check("R1 write address ack", ack, 1);
    wbyte(p, ack);           check("R2 pointer byte ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(seed + 8'(k * 7), ack); check("R2 data ack", ack, 1);
      em[q] = seed + 8'(k * 7); q = q + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic rd_regs(input logic set_ptr, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] b, q;
    q = p;
    i2c_start();
    if (set_ptr) begin
      wbyte({DEV, 1'b0}, ack); wbyte(p, ack);
      i2c_start();
    end
    wbyte({DEV, 1'b1}, ack); check("R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(8'hFF, k != n - 1, b);
      check("R3 read data", b, em[q]);
      q = q + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic ara_cycle(input logic [7:0] pat, output logic ack, output logic [7:0] b);
    i2c_start();
    wbyte({ARA, 1'b1}, ack);
    b = 8'hFF;
    if (ack) rbyte(pat, 1'b0, b);
    i2c_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int w0, r0, s0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; em[i] = 8'(i) ^ 8'h5A; end
    wait_t(5);
    check("R4 reset sda_oe", sda_oe, 0);
    check("R6 reset alert_pull", alert_pull, 0);
    check("R2 reset reg_wr", reg_wr, 0);
    check("R3 reset reg_rd", reg_rd, 0);
    rst_n = 1; wait_t(5);

    // R1 sweep over every write address, with a trailing byte that must be ignored on mismatch
    for (int a = 0; a < 128; a++) begin
      w0 = n_wr;
      i2c_start();
      wbyte({7'(a), 1'b0}, ack);
      check("R1 address ack", ack, (7'(a) == DEV) ? 1 : 0);
      wbyte(8'h80, ack);
      check("R1 trailing byte ack", ack, (7'(a) == DEV) ? 1 : 0);
      wbyte(8'h3C, ack);
      if (7'(a) == DEV) em[8'h80] = 8'h3C;
      i2c_stop();
      check("R1 write strobes", n_wr - w0, (7'(a) == DEV) ? 1 : 0);
    end

    // R2/R3 burst write and read back with repeated START
    wr_regs(8'h05, 4, 8'h91);
    rd_regs(1, 8'h05, 4);
    // R2 pointer wrap
    wr_regs(8'hFE, 3, 8'h21);
    rd_regs(1, 8'hFE, 3);
    // R3 pointer kept after NACK: continue from 0x13 with no pointer byte
    rd_regs(1, 8'h10, 3);
    r0 = n_rd;
    rd_regs(0, 8'h13, 2);
    check("R3 read strobes", n_rd - r0, 2);
    check("R3 pointer after read", reg_addr, 8'h15);
    check("R4 released after stop", sda_oe, 0);

    // R5 status read pulses
    s0 = n_st; rd_regs(1, 8'h00, 2); check("R5 status pulse from 0x00", n_st - s0, 1);
    s0 = n_st; rd_regs(1, 8'h01, 3); check("R5 no status pulse from 0x01", n_st - s0, 0);

    // R7/R9 no alert pending: ARA not acknowledged
    ara_cycle(8'hFF, ack, b); check("R9 ARA ignored without alert", ack, 0);

    // R6 alert set and hold through traffic
    @(negedge clk); alert_evt = 1; @(negedge clk); alert_evt = 0;
    check("R6 alert set", alert_pull, 1);
    wr_regs(8'h40, 2, 8'h07); rd_regs(1, 8'h40, 2);
    check("R6 alert held through traffic", alert_pull, 1);

    // R8 arbitration lost against a competitor sending 0x43
    ara_cycle(8'h43, ack, b);
    check("R8 ARA ack", ack, 1);
    check("R8 bus carries competitor byte", b, 8'h43);
    check("R8 alert kept after loss", alert_pull, 1);

    // R7 clean response
    ara_cycle(8'hFF, ack, b);
    check("R7 ARA ack", ack, 1);
    check("R7 response byte", b, 8'hC8);
    check("R7 alert released", alert_pull, 0);

    // R9 ignored until new event
    ara_cycle(8'hFF, ack, b); check("R9 ARA ignored after success", ack, 0);
    @(negedge clk); alert_evt = 1; @(negedge clk); alert_evt = 0;
    ara_cycle(8'hFF, ack, b);
    check("R9 ARA accepted after new event", ack, 1);
    check("R7 response byte again", b, 8'hC8);
    check("R7 alert released again", alert_pull, 0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule